// File: doc/BRIEF.md
# Slot Reset and Clock-Enable Sequencer

This block drives the two logic outputs that tell a removable card when its power is usable. It takes one "output in tolerance" bit per switched rail from power-good comparators, the host's active-low system reset, and a readback of the bidirectional reference-clock-enable pin. It produces two outputs. The first is a drive-low enable for that clock-enable pin. The pin is open-drain and is pulled up externally, so it reads high only when no one pulls it low. The second is the active-low slot reset that goes to the card.

The clock-enable pin is an undelayed power-good flag: it is released as soon as every rail is in tolerance and pulled low otherwise. The slot reset goes low quickly when any rail drops out or the host asserts reset. It is released only after a long qualification delay. That delay runs while the rails are good, the host reset is released, and the clock-enable pin reads high. The host can therefore hold the pin low to stop the card from leaving reset. Off, shutdown, no-card and standby conditions all reach this block as rails out of tolerance, so in each of them the slot reset is low. All asynchronous inputs pass through a two-flop synchronizer, and every timing value is a parameter in clock cycles.

Top module: `slot_rst_seq`

## Requirements
- R1: While `rst_n` is low, `slot_rst_n_o` is 0 and `clken_drive_low_o` is 1.
- R2: `clken_drive_low_o` goes to 0 exactly SYNC_STAGES+1 clock edges after all `rail_ok_i` bits are 1 at the inputs. It goes back to 1 exactly SYNC_STAGES+1 edges after any bit is 0. It never depends on the host reset or on the pin readback.
- R3: When any `rail_ok_i` bit goes to 0, `slot_rst_n_o` is 0 exactly SYNC_STAGES+1 edges later. With the defaults and a 100 MHz clock this is 30 ns, well inside a 500 ns budget.
- R4: When `host_rst_n_i` goes to 0, even for a single cycle, `slot_rst_n_o` is 0 exactly SYNC_STAGES+1 edges later.
- R5: Call a condition "ready" when all rails are in tolerance, `host_rst_n_i` is 1 and `clken_pin_i` is 1. Once the last of these three becomes true, `slot_rst_n_o` rises exactly RELEASE_CYCLES+SYNC_STAGES+1 edges later, provided R7 does not hold it longer.
- R6: While `clken_pin_i` is held at 0 externally, `slot_rst_n_o` stays 0 even with good rails and the host reset released.
- R7: Once `slot_rst_n_o` falls, it stays 0 for at least MIN_LOW_CYCLES+1 clock cycles whatever the cause. When the release delay has already run out, it rises on exactly the (MIN_LOW_CYCLES+1)-th edge after the edge that drove it low.
- R8: Any interruption of the ready condition during the release delay restarts the full delay from zero.
- R9: While the ready condition holds, a released `slot_rst_n_o` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rail_ok_i | input | NUM_RAILS | Per-rail "output in tolerance" bits (asynchronous) |
| host_rst_n_i | input | 1 | Host system reset, active low (asynchronous) |
| clken_pin_i | input | 1 | Readback of the open-drain clock-enable pin |
| clken_drive_low_o | output | 1 | 1 pulls the clock-enable pin low |
| slot_rst_n_o | output | 1 | Registered active-low slot reset |

## Verification
Every input change reaches the design through SYNC_STAGES flops and then one output register. The clock-enable drive therefore moves SYNC_STAGES+1 edges after a rail change, and a slot-reset assertion follows a rail dropout or host reset by the same count. A release is due RELEASE_CYCLES+SYNC_STAGES+1 edges after the last ready condition appears. If the pin readback is the last condition, the pin's own SYNC_STAGES+1 latency comes first. A min-width release is due MIN_LOW_CYCLES+1 edges after the fall. The stimulus task changes inputs on a falling edge at a known edge count. For each result it queues the value expected both one cycle before the due edge and on the due edge. The monitor compares each queued item at the falling edge whose edge count matches, so the exact cycle is checked, not just the final value.

// File: rtl/slot_seq_pkg.sv
// Shared types for the slot reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package slot_seq_pkg;

    // Synchronized conditions that gate the slot reset release.
    typedef struct packed {
        logic rails_good;   // every rail in tolerance
        logic host_run;     // host system reset released
        logic pin_high;     // clock-enable pin reads high
    } seq_cond_t;

    // True when every release condition is met.
    function automatic logic cond_ready(seq_cond_t c);
        return c.rails_good & c.host_run & c.pin_high;
    endfunction

endpackage

// File: rtl/slot_seq_sync.sv
// Multi-bit synchronizer bank: one independent flop chain per bit.
// Assumes: bits are unrelated level signals; no bus coherency is implied.
module slot_seq_sync #(
    parameter int WIDTH     = 1,
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the raw bit through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= {STAGES{RESET_VAL}};
                end else begin
                    chain <= {chain[STAGES-2:0], async_i[b]};
                end
            end

            assign sync_o[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/slot_seq_timer.sv
// Saturating qualification timer: counts up while clear is low and
// reports done once LIMIT cycles have been counted.
// Assumes: LIMIT >= 1; clear has priority over counting.
module slot_seq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic done
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count towards LIMIT, restart from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == LIM);

endmodule

// File: rtl/slot_rst_seq.sv
// Slot reset and clock-enable sequencer.
// Drives the open-drain clock-enable pin low unless every rail is good,
// asserts the slot reset fast on any dropout or host reset, holds it for
// a minimum width, and releases it after a qualification delay.
// Assumes: all inputs asynchronous; pin has an external pull-up.
module slot_rst_seq
    import slot_seq_pkg::*;
#(
    parameter int NUM_RAILS      = 3,
    parameter int SYNC_STAGES    = 2,
    parameter int RELEASE_CYCLES = 1_000_000,
    parameter int MIN_LOW_CYCLES = 10_000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_ok_i,
    input  logic                 host_rst_n_i,
    input  logic                 clken_pin_i,
    output logic                 clken_drive_low_o,
    output logic                 slot_rst_n_o
);

    localparam int SW = NUM_RAILS + 2;

    logic [SW-1:0] raw_in;
    logic [SW-1:0] synced;
    seq_cond_t     cond;
    logic          rails_good_s;
    logic          host_run_s;
    logic          pin_high_s;
    logic          ready_s;
    logic          rel_done;
    logic          hold_done;
    logic          slot_q;
    logic          drive_low_q;

    assign raw_in = {clken_pin_i, host_rst_n_i, rail_ok_i};

    slot_seq_sync #(
        .WIDTH     (SW),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b0)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (synced)
    );

    // Collect synchronized bits into the condition record.
    always_comb begin
        cond.rails_good = &synced[NUM_RAILS-1:0];
        cond.host_run   = synced[NUM_RAILS];
        cond.pin_high   = synced[NUM_RAILS+1];
    end

    assign rails_good_s = cond.rails_good;
    assign host_run_s   = cond.host_run;
    assign pin_high_s   = cond.pin_high;
    assign ready_s      = cond_ready(cond);

    // Release delay: restarts whenever any condition drops.
    slot_seq_timer #(
        .LIMIT (RELEASE_CYCLES)
    ) i_release (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!ready_s),
        .done  (rel_done)
    );

    // Minimum assertion width: counts only while the slot reset is low.
    slot_seq_timer #(
        .LIMIT (MIN_LOW_CYCLES)
    ) i_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (slot_q),
        .done  (hold_done)
    );

    // Registered slot reset: fast assert, qualified release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= 1'b0;
        end else if (!ready_s) begin
            slot_q <= 1'b0;
        end else if (rel_done && hold_done) begin
            slot_q <= 1'b1;
        end
    end

    // Registered clock-enable pull-down: follows rail health only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_low_q <= 1'b1;
        end else begin
            drive_low_q <= !rails_good_s;
        end
    end

    assign slot_rst_n_o      = slot_q;
    assign clken_drive_low_o = drive_low_q;

endmodule

// File: rtl/slot_rst_seq_chk.sv
// Property checker for slot_rst_seq, attached by bind.
// Assumes: signals are sampled on the block clock; long windows are
// measured with local saturating counters rather than deep $past.
module slot_rst_seq_chk #(
    parameter int RELEASE_CYCLES = 16,
    parameter int MIN_LOW_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic rails_good_s,
    input logic host_run_s,
    input logic pin_high_s,
    input logic ready_s,
    input logic clken_drive_low_o,
    input logic slot_rst_n_o
);

    localparam int LW = $clog2(MIN_LOW_CYCLES + 2);
    localparam int RW = $clog2(RELEASE_CYCLES + 2);
    localparam logic [LW-1:0] LOW_SAT = LW'(MIN_LOW_CYCLES + 1);
    localparam logic [RW-1:0] RDY_SAT = RW'(RELEASE_CYCLES + 1);

    logic [LW-1:0] low_run;
    logic [RW-1:0] rdy_run;

    // Length of the current low phase of the slot reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (slot_rst_n_o) begin
            low_run <= '0;
        end else if (low_run != LOW_SAT) begin
            low_run <= low_run + 1'b1;
        end
    end

    // Length of the current unbroken ready phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_run <= '0;
        end else if (!ready_s) begin
            rdy_run <= '0;
        end else if (rdy_run != RDY_SAT) begin
            rdy_run <= rdy_run + 1'b1;
        end
    end

    p_clken_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rails_good_s |=> !clken_drive_low_o);

    p_clken_pull_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rails_good_s |=> clken_drive_low_o);

    p_rail_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rails_good_s |=> !slot_rst_n_o);

    p_host_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !host_run_s |=> !slot_rst_n_o);

    p_release_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_rst_n_o) |-> (rdy_run >= RW'(RELEASE_CYCLES)));

    p_pin_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_high_s |=> !slot_rst_n_o);

    p_min_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_rst_n_o) |-> (low_run >= LW'(MIN_LOW_CYCLES)));

    p_hold_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_rst_n_o && ready_s) |=> slot_rst_n_o);

endmodule

bind slot_rst_seq slot_rst_seq_chk #(
    .RELEASE_CYCLES (RELEASE_CYCLES),
    .MIN_LOW_CYCLES (MIN_LOW_CYCLES)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .rails_good_s      (rails_good_s),
    .host_run_s        (host_run_s),
    .pin_high_s        (pin_high_s),
    .ready_s           (ready_s),
    .clken_drive_low_o (clken_drive_low_o),
    .slot_rst_n_o      (slot_rst_n_o)
);

// File: tb/test_slot_rst_seq.sv
// Scoreboard bench: stimulus queues (edge count, signal, value) items,
// a monitor compares them at the falling edge with that edge count.
module test_slot_rst_seq;

    localparam int NR  = 3;
    localparam int S   = 2;
    localparam int REL = 8;
    localparam int MIN = 40;
    localparam int L   = S + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rails = '0;
    logic          host_rst_n = 1'b0;
    logic          host_hold = 1'b0;
    logic          pin;
    logic          drv_low;
    logic          slot_n;

    int n_edges = 0;
    int tests   = 0;
    int fails   = 0;
    bit done    = 1'b0;

    typedef struct {
        int    cyc;
        int    sig;   // 0: slot_rst_n_o, 1: clken_drive_low_o
        bit    val;
        string req;
    } exp_t;

    exp_t sb[$];

    // Open-drain pin with pull-up: low if the block or the host pulls it.
    assign pin = !(drv_low || host_hold);

    slot_rst_seq #(
        .NUM_RAILS      (NR),
        .SYNC_STAGES    (S),
        .RELEASE_CYCLES (REL),
        .MIN_LOW_CYCLES (MIN)
    ) i_slot_rst_seq (
        .clk               (clk),
        .rst_n             (rst_n),
        .rail_ok_i         (rails),
        .host_rst_n_i      (host_rst_n),
        .clken_pin_i       (pin),
        .clken_drive_low_o (drv_low),
        .slot_rst_n_o      (slot_n)
    );

    always #5 clk = ~clk;

    // Count rising edges since time zero.
    always @(posedge clk) n_edges <= n_edges + 1;

    task automatic expect_at(input int cyc, input int sig, input bit val, input string req);
        exp_t e;
        e.cyc = cyc; e.sig = sig; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    task automatic wait_until(input int cyc);
        while (n_edges < cyc) @(negedge clk);
    endtask

    // Monitor: compare every item due at this edge count.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == n_edges) begin
                bit act;
                act = (sb[i].sig == 0) ? slot_n : drv_low;
                tests++;
                if (act !== sb[i].val) begin
                    fails++;
                    $display("FAIL %s at edge %0d sig %0d: actual %0b expected %0b",
                             sb[i].req, n_edges, sb[i].sig, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        expect_at(2, 0, 1'b0, "R1");
        expect_at(3, 1, 1'b1, "R1");
        wait_until(5);
        rst_n = 1'b1;

        // Host released, rails still off: slot stays low (R5 needs rails).
        wait_until(60);
        host_rst_n = 1'b1;
        expect_at(80, 0, 1'b0, "R5");
        expect_at(80, 1, 1'b1, "R2");

        // Rails good: pin released after L, slot after L + REL + L.
        wait_until(100);
        rails = '1;
        expect_at(100 + L - 1, 1, 1'b1, "R2");
        expect_at(100 + L,     1, 1'b0, "R2");
        expect_at(100 + 2*L + REL - 1, 0, 1'b0, "R5");
        expect_at(100 + 2*L + REL,     0, 1'b1, "R5");
        expect_at(130, 0, 1'b1, "R9");

        // One rail drops: fast assert and pin pull-down.
        wait_until(140);
        rails = 3'b101;
        expect_at(140 + L - 1, 1, 1'b0, "R2");
        expect_at(140 + L,     1, 1'b1, "R2");
        expect_at(140 + L - 1, 0, 1'b1, "R3");
        expect_at(140 + L,     0, 1'b0, "R3");
        wait_until(200);
        rails = '1;
        expect_at(200 + 2*L + REL - 1, 0, 1'b0, "R5");
        expect_at(200 + 2*L + REL,     0, 1'b1, "R5");

        // One-cycle host reset pulse: fast assert, then min width.
        wait_until(240);
        host_rst_n = 1'b0;
        expect_at(240 + L - 1, 0, 1'b1, "R4");
        expect_at(240 + L,     0, 1'b0, "R4");
        expect_at(240 + L,     1, 1'b0, "R4");
        expect_at(240 + L + MIN,     0, 1'b0, "R7");
        expect_at(240 + L + MIN + 1, 0, 1'b1, "R7");
        wait_until(241);
        host_rst_n = 1'b1;

        // Host holds the pin low: release blocked until it lets go.
        wait_until(320);
        host_rst_n = 1'b0;
        wait_until(330);
        host_hold = 1'b1;
        wait_until(335);
        host_rst_n = 1'b1;
        expect_at(350, 1, 1'b0, "R6");
        expect_at(366, 0, 1'b0, "R6");
        expect_at(399, 0, 1'b0, "R6");
        wait_until(400);
        host_hold = 1'b0;
        expect_at(400 + L + REL - 1, 0, 1'b0, "R5");
        expect_at(400 + L + REL,     0, 1'b1, "R5");

        // Restart: a one-cycle rail glitch inside the delay.
        wait_until(440);
        host_rst_n = 1'b0;
        wait_until(490);
        host_rst_n = 1'b1;
        expect_at(490 + L + REL, 0, 1'b0, "R8");
        wait_until(495);
        rails = 3'b110;
        wait_until(496);
        rails = '1;
        // Pin readback is low at edge 500, ready again from edge 501.
        expect_at(501 + REL, 0, 1'b0, "R8");
        expect_at(502 + REL, 0, 1'b1, "R8");

        wait_until(560);
        if (sb.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule